// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

A synchronous memory shared by two fully independent ports, called left and right. Each port has an enable, an output enable, a write select, an address and split write/read data buses, so either side can read or write any word in any cycle. The array holds 2**ADDR_W words of DATA_W bits. The intended build uses ADDR_W = 13 (8K words) and DATA_W of 8 or 9. The default parameters elaborate a smaller array.

When both ports are enabled on the same word in the same cycle, an arbiter picks one winner. It flags the other port on its busy output and discards a write from that port. A writer is preferred over a reader. Between two readers or two writers, the left port wins, unless the right port already held that word in the previous cycle without losing. In that case the right port keeps the word for as long as the collision lasts.

The two highest addresses serve as mailboxes. A write by one port into the other port's mailbox raises an active-low interrupt toward that other port. The interrupt drops again when the receiving port reads its mailbox.

Top module: `dual_port_mailbox_ram`

## Requirements
- R1: Every word written through either port reads back unchanged, all DATA_W bits of it (bit 8 included when DATA_W is 9), from either port at any address, the lowest and the mailboxes included.
- R2: A read (enable high, write select low, output enable high) presents the stored word on that port's read bus in the following cycle. In any other cycle, including a read with output enable low, the read bus shows zero in the following cycle.
- R3: The two ports can write different addresses in the same cycle, and both writes take effect.
- R4: When one port reads a word that the other port writes in the same cycle, the read returns the value from before that write.
- R5: When both ports are enabled on the same address, exactly one busy output is high in the next cycle, and it belongs to the losing port. Both busy outputs are never high together.
- R6: When the addresses differ or a port is idle, both busy outputs are low in the next cycle. When one port writes and the other reads the same address, the writer wins and the reader's busy goes high.
- R7: When both ports write the same address, the right port wins only if it was enabled on that address in the previous cycle without losing. Otherwise the left port wins. The loser's write is discarded.
- R8: The left interrupt (active low, registered) goes low in the cycle after the right port writes address 2**ADDR_W-2. It returns high in the cycle after the left port reads that address. Otherwise it holds.
- R9: The right interrupt (active low, registered) goes low in the cycle after the left port writes address 2**ADDR_W-1. It returns high in the cycle after the right port reads that address. Otherwise it holds.
- R10: When a port writes the other port's mailbox in the same cycle that the other port reads it, the interrupt ends up low.
- R11: A port writing its own incoming mailbox, or reading the other port's mailbox, changes neither interrupt.
- R12: While the synchronous reset is high, both read buses and both busy outputs are zero and both interrupts are high. The memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_ce | input | 1 | Left port enable |
| l_oe | input | 1 | Left port output enable for reads |
| l_wr | input | 1 | Left port write select (1 = write) |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle after the read |
| l_busy | output | 1 | Left port lost arbitration in the previous cycle |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_ce | input | 1 | Right port enable |
| r_oe | input | 1 | Right port output enable for reads |
| r_wr | input | 1 | Right port write select (1 = write) |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle after the read |
| r_busy | output | 1 | Right port lost arbitration in the previous cycle |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The assertions check on every cycle that the busy outputs are mutually exclusive, that they follow a collision or its absence, and that a writer beats a reader. They also check that each interrupt rises, falls and holds exactly on its mailbox accesses, and that an idle or disabled read bus is zero. Only the bench's scenarios can show the data itself: read-first ordering across the ports, which of two colliding writes survives under the held-priority rule, and the full-width contents read back at the edge addresses.

// File: rtl/dpm_pkg.sv
package dpm_pkg;

  // Outcome of address arbitration for one cycle.
  typedef struct packed {
    logic match;
    logic lose_l;
    logic lose_r;
  } arb_t;

  // Port index used across the arrays in the top.
  localparam int PORT_L = 0;
  localparam int PORT_R = 1;
  localparam int NPORTS = 2;

endpackage

// File: rtl/dpm_arbiter.sv
module dpm_arbiter
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  output arb_t              arb,
  output logic              l_busy_q,
  output logic              r_busy_q
);

  // Right port's holding of a word in the previous cycle.
  logic              r_held_q;
  logic [ADDR_W-1:0] r_addr_q;
  logic              right_first;

  assign right_first = r_held_q && (r_addr_q == r_addr);

  always_comb begin
    arb       = '0;
    arb.match = l_ce && r_ce && (l_addr == r_addr);
    if (arb.match) begin
      if (l_wr && !r_wr) begin
        arb.lose_r = 1'b1;
      end else if (r_wr && !l_wr) begin
        arb.lose_l = 1'b1;
      end else if (right_first) begin
        arb.lose_l = 1'b1;
      end else begin
        arb.lose_r = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_held_q <= 1'b0;
      r_addr_q <= '0;
      l_busy_q <= 1'b0;
      r_busy_q <= 1'b0;
    end else begin
      r_held_q <= r_ce && !arb.lose_r;
      r_addr_q <= r_addr;
      l_busy_q <= arb.lose_l;
      r_busy_q <= arb.lose_r;
    end
  end

endmodule

// File: rtl/dpm_storage.sv
module dpm_storage
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NPORTS-1:0]              wen,
  input  logic [NPORTS-1:0]              ren,
  input  logic [NPORTS-1:0][ADDR_W-1:0]  addr,
  input  logic [NPORTS-1:0][DATA_W-1:0]  wdata,
  output logic [NPORTS-1:0][DATA_W-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write side: arbitration guarantees at most one write per word.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPORTS; p++) begin
      if (wen[p]) begin
        mem[addr[p]] <= wdata[p];
      end
    end
  end

  // Read registers: nonblocking, so reads see pre-write contents.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        rdata[p] <= ren[p] ? mem[addr[p]] : '0;
      end
    end
  end

endmodule

// File: rtl/dpm_mailbox.sv
module dpm_mailbox (
  input  logic clk,
  input  logic rst,
  input  logic post_i,
  input  logic take_i,
  output logic irq_n_o
);

  // Posting dominates taking in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n_o <= 1'b1;
    end else if (post_i) begin
      irq_n_o <= 1'b0;
    end else if (take_i) begin
      irq_n_o <= 1'b1;
    end
  end

endmodule

// File: rtl/dual_port_mailbox_ram.sv
module dual_port_mailbox_ram
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce,
  input  logic              l_oe,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy,
  output logic              l_irq_n,
  input  logic              r_ce,
  input  logic              r_oe,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy,
  output logic              r_irq_n
);

  // Incoming mailbox of each port: left at top-1, right at top.
  localparam logic [ADDR_W-1:0] MBX_IN_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] MBX_IN_R = {ADDR_W{1'b1}};

  arb_t arb;

  logic [NPORTS-1:0]             ce, wr, oe, lose, wen, ren, rd_any;
  logic [NPORTS-1:0][ADDR_W-1:0] addr;
  logic [NPORTS-1:0][DATA_W-1:0] wdata, rdata;
  logic [NPORTS-1:0][ADDR_W-1:0] mbx_in;
  logic [NPORTS-1:0]             irq_n;

  assign ce     = {r_ce, l_ce};
  assign wr     = {r_wr, l_wr};
  assign oe     = {r_oe, l_oe};
  assign addr   = {r_addr, l_addr};
  assign wdata  = {r_wdata, l_wdata};
  assign lose   = {arb.lose_r, arb.lose_l};
  assign mbx_in = {MBX_IN_R, MBX_IN_L};

  dpm_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .l_ce     (l_ce),
    .l_wr     (l_wr),
    .l_addr   (l_addr),
    .r_ce     (r_ce),
    .r_wr     (r_wr),
    .r_addr   (r_addr),
    .arb      (arb),
    .l_busy_q (l_busy),
    .r_busy_q (r_busy)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam int OTHER = NPORTS - 1 - p;
    logic post, take;

    assign wen[p]    = ce[p] && wr[p] && !lose[p];
    assign rd_any[p] = ce[p] && !wr[p];
    assign ren[p]    = rd_any[p] && oe[p];

    // Other port posts into this port's mailbox; this port takes it.
    assign post = ce[OTHER] && wr[OTHER] && !lose[OTHER] && (addr[OTHER] == mbx_in[p]);
    assign take = rd_any[p] && (addr[p] == mbx_in[p]);

    dpm_mailbox u_mbx (
      .clk     (clk),
      .rst     (rst),
      .post_i  (post),
      .take_i  (take),
      .irq_n_o (irq_n[p])
    );
  end

  dpm_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .wen   (wen),
    .ren   (ren),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  assign l_rdata = rdata[PORT_L];
  assign r_rdata = rdata[PORT_R];
  assign l_irq_n = irq_n[PORT_L];
  assign r_irq_n = irq_n[PORT_R];

endmodule

// File: rtl/dpm_checker.sv
module dpm_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              l_ce,
  input logic              l_oe,
  input logic              l_wr,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_busy,
  input logic              l_irq_n,
  input logic              r_ce,
  input logic              r_oe,
  input logic              r_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_busy,
  input logic              r_irq_n
);

  localparam logic [ADDR_W-1:0] MB_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] MB_R = {ADDR_W{1'b1}};

  logic same, r_post_l, l_post_l, l_take_l, l_post_r, r_post_r, r_take_r;
  assign same     = l_ce && r_ce && (l_addr == r_addr);
  assign r_post_l = r_ce && r_wr && (r_addr == MB_L);
  assign l_post_l = l_ce && l_wr && (l_addr == MB_L);
  assign l_take_l = l_ce && !l_wr && (l_addr == MB_L);
  assign l_post_r = l_ce && l_wr && (l_addr == MB_R);
  assign r_post_r = r_ce && r_wr && (r_addr == MB_R);
  assign r_take_r = r_ce && !r_wr && (r_addr == MB_R);

  p_busy_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(l_busy && r_busy));
  p_match_busy_r5: assert property (@(posedge clk) disable iff (rst)
    same |=> (l_busy || r_busy));
  p_no_match_r6: assert property (@(posedge clk) disable iff (rst)
    !same |=> (!l_busy && !r_busy));
  p_writer_l_r6: assert property (@(posedge clk) disable iff (rst)
    (same && l_wr && !r_wr) |=> (r_busy && !l_busy));
  p_writer_r_r6: assert property (@(posedge clk) disable iff (rst)
    (same && r_wr && !l_wr) |=> (l_busy && !r_busy));
  p_rdata_l_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !(l_ce && !l_wr && l_oe) |=> (l_rdata == '0));
  p_rdata_r_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !(r_ce && !r_wr && r_oe) |=> (r_rdata == '0));
  p_lirq_set_r8: assert property (@(posedge clk) disable iff (rst)
    (r_post_l && !l_post_l) |=> !l_irq_n);
  p_lirq_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (l_take_l && !r_post_l) |=> l_irq_n);
  p_lirq_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!r_post_l && !l_take_l) |=> $stable(l_irq_n));
  p_rirq_set_r9: assert property (@(posedge clk) disable iff (rst)
    (l_post_r && !r_post_r) |=> !r_irq_n);
  p_rirq_clr_r9: assert property (@(posedge clk) disable iff (rst)
    (r_take_r && !l_post_r) |=> r_irq_n);
  p_rirq_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!l_post_r && !r_take_r) |=> $stable(r_irq_n));
  p_both_mbx_r10: assert property (@(posedge clk) disable iff (rst)
    (r_post_l && l_take_l) |=> !l_irq_n);

endmodule

bind dual_port_mailbox_ram dpm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .l_ce    (l_ce),
  .l_oe    (l_oe),
  .l_wr    (l_wr),
  .l_addr  (l_addr),
  .l_rdata (l_rdata),
  .l_busy  (l_busy),
  .l_irq_n (l_irq_n),
  .r_ce    (r_ce),
  .r_oe    (r_oe),
  .r_wr    (r_wr),
  .r_addr  (r_addr),
  .r_rdata (r_rdata),
  .r_busy  (r_busy),
  .r_irq_n (r_irq_n)
);

// File: tb/tb_dual_port_mailbox_ram.sv
module tb_dual_port_mailbox_ram;

  localparam int AW    = 10;
  localparam int DW    = 9;
  localparam int MBX_L = (1 << AW) - 2;
  localparam int MBX_R = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst;
  logic l_ce, l_oe, l_wr, r_ce, r_oe, r_wr;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_busy, r_busy, l_irq_n, r_irq_n;

  always #5 clk = ~clk;

  dual_port_mailbox_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst),
    .l_ce(l_ce), .l_oe(l_oe), .l_wr(l_wr), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy(l_busy), .l_irq_n(l_irq_n),
    .r_ce(r_ce), .r_oe(r_oe), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy(r_busy), .r_irq_n(r_irq_n)
  );

  typedef struct {
    string         tag;
    int            sel;
    logic [DW-1:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Requirement-level model state
  logic [DW-1:0] mm [int];
  bit m_rheld, m_lflag, m_rflag;
  int m_raddr;

  function automatic logic [DW-1:0] observe(int s);
    case (s)
      0: return l_rdata;
      1: return r_rdata;
      2: return DW'(l_busy);
      3: return DW'(r_busy);
      4: return DW'(l_irq_n);
      default: return DW'(r_irq_n);
    endcase
  endfunction

  function automatic string sname(int s);
    case (s)
      0: return "l_rdata";
      1: return "r_rdata";
      2: return "l_busy";
      3: return "r_busy";
      4: return "l_irq_n";
      default: return "r_irq_n";
    endcase
  endfunction

  task automatic expect_item(string tag, int sel, logic [DW-1:0] exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  // Monitor: pops the scoreboard away from the active edge.
  always @(negedge clk) begin : mon
    item_t it;
    logic [DW-1:0] act;
    while (q.size() > 0) begin
      it  = q.pop_front();
      act = observe(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", it.tag, sname(it.sel), act, it.exp);
      end
    end
  end

  // Driver: one cycle of stimulus plus the expected outputs after the edge.
  task automatic step(string tag,
                      bit lce, bit loe, bit lwr, int la, logic [DW-1:0] lwd,
                      bit rce, bit roe, bit rwr, int ra, logic [DW-1:0] rwd);
    bit match, lose_l, lose_r, lset, lclr, rset, rclr;
    @(negedge clk);
    l_ce = lce; l_oe = loe; l_wr = lwr; l_addr = AW'(la); l_wdata = lwd;
    r_ce = rce; r_oe = roe; r_wr = rwr; r_addr = AW'(ra); r_wdata = rwd;
    match  = lce && rce && (la == ra);
    lose_l = 1'b0;
    lose_r = 1'b0;
    if (match) begin
      if (lwr && !rwr) lose_r = 1'b1;
      else if (rwr && !lwr) lose_l = 1'b1;
      else if (m_rheld && m_raddr == ra) lose_l = 1'b1;
      else lose_r = 1'b1;
    end
    @(posedge clk);
    if (lce && !lwr && loe) begin
      if (mm.exists(la)) expect_item(tag, 0, mm[la]);
    end else expect_item(tag, 0, '0);
    if (rce && !rwr && roe) begin
      if (mm.exists(ra)) expect_item(tag, 1, mm[ra]);
    end else expect_item(tag, 1, '0);
    expect_item(tag, 2, DW'(lose_l));
    expect_item(tag, 3, DW'(lose_r));
    lset = rce && rwr && !lose_r && (ra == MBX_L);
    lclr = lce && !lwr && (la == MBX_L);
    rset = lce && lwr && !lose_l && (la == MBX_R);
    rclr = rce && !rwr && (ra == MBX_R);
    if (lset) m_lflag = 1'b1; else if (lclr) m_lflag = 1'b0;
    if (rset) m_rflag = 1'b1; else if (rclr) m_rflag = 1'b0;
    expect_item(tag, 4, DW'(!m_lflag));
    expect_item(tag, 5, DW'(!m_rflag));
    if (lce && lwr && !lose_l) mm[la] = lwd;
    if (rce && rwr && !lose_r) mm[ra] = rwd;
    m_rheld = rce && !lose_r;
    m_raddr = ra;
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, '0, 0, 0, 0, 0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    rst = 1'b1;
    l_ce = 0; l_oe = 0; l_wr = 0; l_addr = '0; l_wdata = '0;
    r_ce = 0; r_oe = 0; r_wr = 0; r_addr = '0; r_wdata = '0;
    m_rheld = 0; m_lflag = 0; m_rflag = 0; m_raddr = 0;
    repeat (2) @(posedge clk);
    // R12: reset state
    expect_item("R12", 0, '0);
    expect_item("R12", 1, '0);
    expect_item("R12", 2, '0);
    expect_item("R12", 3, '0);
    expect_item("R12", 4, 9'd1);
    expect_item("R12", 5, 9'd1);
    @(negedge clk);
    rst = 1'b0;

    // R3 / R1: independent writes at distinct addresses, edge addresses
    step("R3", 1, 0, 1, 0, 9'h1A5, 1, 0, 1, 5, 9'h15A);
    step("R3", 1, 0, 1, MBX_L - 1, 9'h100, 1, 0, 1, 1, 9'h03C);
    step("R1", 1, 1, 0, 5, '0, 1, 1, 0, 0, '0);
    step("R1", 1, 1, 0, 1, '0, 1, 1, 0, MBX_L - 1, '0);
    // R2: output enable low gives zero
    step("R2", 1, 0, 0, 0, '0, 0, 0, 0, 0, '0);
    idle("R2");
    // R4 / R6: left writes while right reads the same word
    step("R4", 1, 0, 1, 5, 9'h0AA, 1, 1, 0, 5, '0);
    // R5: both read the same word
    step("R5", 1, 1, 0, 5, '0, 1, 1, 0, 5, '0);
    // R7: fresh collision of two writes, left wins
    step("R7", 1, 0, 1, 9, 9'h111, 1, 0, 1, 9, 9'h122);
    step("R7", 1, 1, 0, 9, '0, 0, 0, 0, 0, '0);
    // R7: right already on the word keeps it
    step("R7", 0, 0, 0, 0, '0, 1, 1, 0, 12, '0);
    step("R7", 1, 0, 1, 12, 9'h0C3, 1, 0, 1, 12, 9'h13C);
    step("R7", 1, 0, 1, 12, 9'h001, 1, 0, 1, 12, 9'h002);
    step("R7", 1, 1, 0, 12, '0, 0, 0, 0, 0, '0);
    // R6: different addresses, no busy
    step("R6", 1, 0, 1, 20, 9'h020, 1, 0, 1, 21, 9'h021);
    step("R6", 1, 1, 0, 21, '0, 1, 1, 0, 20, '0);
    // R8: left mailbox
    step("R8", 0, 0, 0, 0, '0, 1, 0, 1, MBX_L, 9'h055);
    idle("R8");
    step("R8", 1, 1, 0, MBX_L, '0, 0, 0, 0, 0, '0);
    // R9: right mailbox
    step("R9", 1, 0, 1, MBX_R, 9'h1EE, 0, 0, 0, 0, '0);
    idle("R9");
    step("R9", 0, 0, 0, 0, '0, 1, 1, 0, MBX_R, '0);
    // R10: post and take in the same cycle
    step("R10", 1, 1, 0, MBX_L, '0, 1, 0, 1, MBX_L, 9'h077);
    idle("R10");
    step("R10", 1, 0, 0, MBX_L, '0, 0, 0, 0, 0, '0);
    // R11: own-mailbox writes and foreign-mailbox reads change nothing
    step("R11", 1, 0, 1, MBX_L, 9'h0B0, 1, 1, 0, MBX_L, '0);
    step("R11", 1, 1, 0, MBX_R, '0, 1, 0, 1, MBX_R, 9'h0B1);
    step("R11", 1, 1, 0, MBX_L, '0, 1, 1, 0, MBX_R, '0);
    idle("R12");
    @(negedge clk);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R12 actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule